// File: doc/BRIEF.md
# Shared Pool Buffer Allocator

This block hands out packet buffer segments for a multi-port switch. It treats all segments as one pool. A port asks for a segment and, in the same cycle, either gets a segment index or is refused. Later it hands that index back. The block records which port holds each segment and how many segments each port holds. It also keeps a running count of free segments.

Two modes set how the pool is split. In fixed mode, every port owns an equal slice of consecutive segments whether or not the port is enabled, so the slices of disabled ports lie idle. In shared mode, any free segment may go to any enabled port. Each enabled port's quota is the pool size divided by the number of enabled ports, and the remainder is handed out one extra segment at a time, starting from the lowest-numbered enabled port. The mode and the port-enable mask are loaded through a configuration strobe. A new configuration is taken only while the pool is fully idle.

Top module: `seg_pool_alloc`

## Requirements
- R1: After reset, all 30 segments are free (`free_count` = 30), every port's occupancy is 0, the mode is fixed and all six ports are enabled.
- R2: In fixed mode (`cfg_shared` = 0), port p is granted only segments 5p to 5p+4, always the lowest-numbered free one in that slice. Its sixth outstanding request is denied.
- R3: A disabled port is always denied. In fixed mode, an enabled port is denied once its own slice is used up, even while segments in other ports' slices are free.
- R4: In shared mode (`cfg_shared` = 1) with n enabled ports, each enabled port's quota is floor(30/n). The lowest-numbered (30 mod n) enabled ports each get one more. With mask 6'b110101 the quotas of ports 0, 2, 4, 5 are 8, 8, 7, 7.
- R5: In shared mode, a grant returns the lowest-numbered free segment in the whole pool.
- R6: `alloc_grant` or `alloc_deny` answers a request combinationally in its own cycle. A grant needs the port to be below its quota and a suitable segment to be free. `alloc_seg` is valid together with `alloc_grant`.
- R7: A valid free puts the segment back in the pool, lowers that port's occupancy by one and raises `free_count` by one after the clock edge.
- R8: A free of a segment that is already free, that another port holds, or whose index is 30 or above raises `free_err` in the same cycle and changes no state.
- R9: `cfg_write` loads mode and mask only when every occupancy is zero and no allocate is requested in that cycle. Otherwise `cfg_err` is raised in that cycle and the old configuration is kept.
- R10: An allocate and a free in the same cycle are both served and `free_count` is unchanged. The segment being freed is not offered to the allocate in that cycle.
- R11: The sum of all occupancies plus `free_count` always equals 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write | input | 1 | Load a new mode and mask |
| cfg_shared | input | 1 | Mode to load: 0 fixed, 1 shared |
| cfg_port_en | input | 6 | Port-enable mask to load, bit p for port p |
| cfg_err | output | 1 | Configuration refused this cycle |
| alloc_req | input | 1 | Allocate request |
| alloc_port | input | 3 | Requesting port |
| alloc_grant | output | 1 | Request granted |
| alloc_deny | output | 1 | Request refused |
| alloc_seg | output | 5 | Granted segment index |
| free_req | input | 1 | Free request |
| free_port | input | 3 | Port returning the segment |
| free_seg | input | 5 | Segment index returned |
| free_err | output | 1 | Free refused as invalid |
| free_count | output | 5 | Number of free segments |
| occupancy | output | 30 | Per-port held count, 5 bits per port, port p at bits 5p+4:5p |

## Verification
The bench builds the block with its default parameters: six ports and thirty segments. With these values, fixed slices hold five segments, and a four-port mask gives an uneven 8/8/7/7 split, so the remainder rule is exercised. The pool can also be filled completely in shared mode, which puts a same-cycle allocate and free against a nearly empty pool. This lets the bench show that a freed segment is not offered to an allocate in the cycle it is returned.

// File: rtl/segpool_pkg.sv
package segpool_pkg;

    localparam int DEF_NPORT = 6;
    localparam int DEF_NSEG  = 30;

    typedef enum logic {
        POOL_FIXED  = 1'b0,
        POOL_SHARED = 1'b1
    } pool_mode_e;

    // Quota of port p for a given mode and enable mask.
    function automatic int port_quota(pool_mode_e mode, logic [31:0] en,
                                      int nport, int nseg, int p);
        int n;
        int rank;
        n = 0;
        rank = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < nport && en[i]) begin
                n++;
                if (i < p) rank++;
            end
        end
        if (p >= nport || !en[p] || n == 0) return 0;
        if (mode == POOL_FIXED) return nseg / nport;
        return nseg / n + ((rank < (nseg % n)) ? 1 : 0);
    endfunction

endpackage

// File: rtl/seg_quota.sv
module seg_quota
    import segpool_pkg::*;
#(
    parameter int NPORT = DEF_NPORT,
    parameter int NSEG  = DEF_NSEG,
    parameter int CNT_W = $clog2(NSEG + 1)
) (
    input  pool_mode_e                    mode,
    input  logic [NPORT-1:0]              en,
    output logic [NPORT-1:0][CNT_W-1:0]   quota
);

    for (genvar p = 0; p < NPORT; p++) begin : g_quota
        assign quota[p] = CNT_W'(port_quota(mode, 32'(en), NPORT, NSEG, p));
    end

endmodule

// File: rtl/seg_freemap.sv
module seg_freemap
    import segpool_pkg::*;
#(
    parameter int NPORT  = DEF_NPORT,
    parameter int NSEG   = DEF_NSEG,
    parameter int PORT_W = $clog2(NPORT),
    parameter int SEG_W  = $clog2(NSEG),
    parameter int CNT_W  = $clog2(NSEG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  pool_mode_e        mode,
    input  logic [PORT_W-1:0] alloc_port,
    input  logic              alloc_fire,
    input  logic              free_fire,
    input  logic [PORT_W-1:0] free_port,
    input  logic [SEG_W-1:0]  free_seg,
    output logic [SEG_W-1:0]  cand_seg,
    output logic              cand_ok,
    output logic              free_owned,
    output logic [CNT_W-1:0]  free_cnt
);

    localparam int SLICE = NSEG / NPORT;

    logic [NSEG-1:0]             avail;
    logic [NSEG-1:0][PORT_W-1:0] owner;

    // Lowest free segment inside the window the mode allows.
    always_comb begin
        int lo;
        int hi;
        if (mode == POOL_FIXED) begin
            lo = int'(alloc_port) * SLICE;
            hi = lo + SLICE - 1;
        end else begin
            lo = 0;
            hi = NSEG - 1;
        end
        cand_ok  = 1'b0;
        cand_seg = '0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (avail[i] && i >= lo && i <= hi) begin
                cand_ok  = 1'b1;
                cand_seg = SEG_W'(i);
            end
        end
    end

    always_comb begin
        free_owned = 1'b0;
        if (int'(free_seg) < NSEG)
            free_owned = !avail[free_seg] && (owner[free_seg] == free_port);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avail    <= '1;
            owner    <= '0;
            free_cnt <= CNT_W'(NSEG);
        end else begin
            if (alloc_fire) begin
                avail[cand_seg] <= 1'b0;
                owner[cand_seg] <= alloc_port;
            end
            if (free_fire)
                avail[free_seg] <= 1'b1;
            free_cnt <= free_cnt + CNT_W'(free_fire) - CNT_W'(alloc_fire);
        end
    end

    AST_CNT_MATCHES_MAP: assert property (@(posedge clk) disable iff (rst)
        free_cnt == CNT_W'($countones(avail)));                              // R11
    AST_TAKEN_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> !avail[$past(cand_seg)]);                             // R5
    AST_BACK_AFTER_FREE: assert property (@(posedge clk) disable iff (rst)
        free_fire |=> avail[$past(free_seg)]);                               // R7
    AST_FIXED_SLICE: assert property (@(posedge clk) disable iff (rst)
        (alloc_fire && mode == POOL_FIXED) |->
            (int'(cand_seg) / SLICE == int'(alloc_port)));                   // R2

endmodule

// File: rtl/seg_occ.sv
module seg_occ #(
    parameter int NPORT  = 6,
    parameter int PORT_W = 3,
    parameter int CNT_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         inc,
    input  logic [PORT_W-1:0]            inc_port,
    input  logic                         dec,
    input  logic [PORT_W-1:0]            dec_port,
    output logic [NPORT-1:0][CNT_W-1:0]  occ
);

    for (genvar p = 0; p < NPORT; p++) begin : g_cnt
        logic up;
        logic down;
        assign up   = inc && (int'(inc_port) == p);
        assign down = dec && (int'(dec_port) == p);

        always_ff @(posedge clk) begin
            if (rst)
                occ[p] <= '0;
            else
                occ[p] <= occ[p] + CNT_W'(up) - CNT_W'(down);
        end

        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
            down |-> occ[p] != '0);                                          // R7
    end

endmodule

// File: rtl/seg_pool_alloc.sv
module seg_pool_alloc
    import segpool_pkg::*;
#(
    parameter int NPORT = DEF_NPORT,
    parameter int NSEG  = DEF_NSEG,
    localparam int PORT_W = $clog2(NPORT),
    localparam int SEG_W  = $clog2(NSEG),
    localparam int CNT_W  = $clog2(NSEG + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_write,
    input  logic                    cfg_shared,
    input  logic [NPORT-1:0]        cfg_port_en,
    output logic                    cfg_err,
    input  logic                    alloc_req,
    input  logic [PORT_W-1:0]       alloc_port,
    output logic                    alloc_grant,
    output logic                    alloc_deny,
    output logic [SEG_W-1:0]        alloc_seg,
    input  logic                    free_req,
    input  logic [PORT_W-1:0]       free_port,
    input  logic [SEG_W-1:0]        free_seg,
    output logic                    free_err,
    output logic [CNT_W-1:0]        free_count,
    output logic [NPORT*CNT_W-1:0]  occupancy
);

    pool_mode_e                  mode_q;
    logic [NPORT-1:0]            en_q;
    logic [NPORT-1:0][CNT_W-1:0] quota;
    logic [NPORT-1:0][CNT_W-1:0] occ;
    logic [SEG_W-1:0]            cand_seg;
    logic                        cand_ok;
    logic                        free_owned;
    logic                        free_fire;
    logic                        below_quota;
    logic                        pool_idle;
    logic                        cfg_take;

    seg_quota #(.NPORT(NPORT), .NSEG(NSEG), .CNT_W(CNT_W)) u_quota (
        .mode  (mode_q),
        .en    (en_q),
        .quota (quota)
    );

    seg_freemap #(.NPORT(NPORT), .NSEG(NSEG), .PORT_W(PORT_W),
                  .SEG_W(SEG_W), .CNT_W(CNT_W)) u_map (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .alloc_port (alloc_port),
        .alloc_fire (alloc_grant),
        .free_fire  (free_fire),
        .free_port  (free_port),
        .free_seg   (free_seg),
        .cand_seg   (cand_seg),
        .cand_ok    (cand_ok),
        .free_owned (free_owned),
        .free_cnt   (free_count)
    );

    seg_occ #(.NPORT(NPORT), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .inc      (alloc_grant),
        .inc_port (alloc_port),
        .dec      (free_fire),
        .dec_port (free_port),
        .occ      (occ)
    );

    always_comb begin
        below_quota = 1'b0;
        if (int'(alloc_port) < NPORT)
            below_quota = occ[alloc_port] < quota[alloc_port];
        alloc_grant = alloc_req && below_quota && cand_ok;
        alloc_deny  = alloc_req && !alloc_grant;
        alloc_seg   = alloc_grant ? cand_seg : '0;
        free_fire   = free_req && free_owned;
        free_err    = free_req && !free_owned;
        pool_idle   = (occ == '0) && !alloc_req;
        cfg_take    = cfg_write && pool_idle;
        cfg_err     = cfg_write && !pool_idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= POOL_FIXED;
            en_q   <= '1;
        end else if (cfg_take) begin
            mode_q <= cfg_shared ? POOL_SHARED : POOL_FIXED;
            en_q   <= cfg_port_en;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_out
        assign occupancy[p*CNT_W +: CNT_W] = occ[p];

        AST_OCC_WITHIN_QUOTA: assert property (@(posedge clk) disable iff (rst)
            occ[p] <= quota[p]);                                             // R4
    end

    int occ_total;
    always_comb begin
        occ_total = 0;
        for (int p = 0; p < NPORT; p++) occ_total += int'(occ[p]);
    end

    AST_POOL_CONSERVED: assert property (@(posedge clk) disable iff (rst)
        occ_total + int'(free_count) == NSEG);                               // R11
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> ($stable(mode_q) && $stable(en_q)));                     // R9
    AST_DISABLED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        alloc_grant |-> en_q[alloc_port]);                                   // R3
    AST_SAME_CYCLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (alloc_grant && free_fire) |=> $stable(free_count));                 // R10

endmodule

// File: tb/seg_pool_alloc_test.sv
module seg_pool_alloc_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_write = 1'b0;
    logic        cfg_shared = 1'b0;
    logic [5:0]  cfg_port_en = '0;
    logic        cfg_err;
    logic        alloc_req = 1'b0;
    logic [2:0]  alloc_port = '0;
    logic        alloc_grant;
    logic        alloc_deny;
    logic [4:0]  alloc_seg;
    logic        free_req = 1'b0;
    logic [2:0]  free_port = '0;
    logic [4:0]  free_seg = '0;
    logic        free_err;
    logic [4:0]  free_count;
    logic [29:0] occupancy;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    seg_pool_alloc uut (
        .clk(clk), .rst(rst),
        .cfg_write(cfg_write), .cfg_shared(cfg_shared), .cfg_port_en(cfg_port_en),
        .cfg_err(cfg_err),
        .alloc_req(alloc_req), .alloc_port(alloc_port),
        .alloc_grant(alloc_grant), .alloc_deny(alloc_deny), .alloc_seg(alloc_seg),
        .free_req(free_req), .free_port(free_port), .free_seg(free_seg),
        .free_err(free_err), .free_count(free_count), .occupancy(occupancy)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int occ_of(int p);
        return int'(occupancy[p*5 +: 5]);
    endfunction

    task automatic alloc1(int port, bit grant, int seg, string tag);
        @(negedge clk);
        alloc_req = 1'b1;
        alloc_port = 3'(port);
        #1;
        chk({tag, " grant"}, int'(alloc_grant), int'(grant));
        chk({tag, " deny"}, int'(alloc_deny), int'(!grant));
        if (grant) chk({tag, " seg"}, int'(alloc_seg), seg);
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic free1(int port, int seg, bit err, string tag);
        @(negedge clk);
        free_req = 1'b1;
        free_port = 3'(port);
        free_seg = 5'(seg);
        #1;
        chk({tag, " free_err"}, int'(free_err), int'(err));
        @(negedge clk);
        free_req = 1'b0;
    endtask

    task automatic cfg1(bit shared, logic [5:0] mask, bit err, string tag);
        @(negedge clk);
        cfg_write = 1'b1;
        cfg_shared = shared;
        cfg_port_en = mask;
        #1;
        chk({tag, " cfg_err"}, int'(cfg_err), int'(err));
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 free_count", int'(free_count), 30);
        for (int p = 0; p < 6; p++) chk("R1 occupancy", occ_of(p), 0);
        alloc1(5, 1, 25, "R1 fixed mode port5 slice");
        free1(5, 25, 0, "R1 return");
    endtask

    task automatic t_fixed();
        for (int k = 0; k < 5; k++) alloc1(2, 1, 10 + k, "R2 slice");
        alloc1(2, 0, 0, "R2 sixth");
        chk("R2 free_count", int'(free_count), 25);
        chk("R2 occ", occ_of(2), 5);
        free1(2, 12, 0, "R7 valid");
        chk("R7 free_count", int'(free_count), 26);
        chk("R7 occ", occ_of(2), 4);
        alloc1(2, 1, 12, "R2 lowest free");
        free1(3, 13, 1, "R8 not owner");
        free1(4, 20, 1, "R8 already free");
        free1(2, 31, 1, "R8 out of range");
        chk("R8 free_count", int'(free_count), 25);
        chk("R8 occ", occ_of(2), 5);
        for (int k = 10; k < 15; k++) free1(2, k, 0, "R7 drain");
        chk("R7 drained", int'(free_count), 30);
    endtask

    task automatic t_cfg_busy();
        alloc1(0, 1, 0, "R9 hold one");
        cfg1(1'b1, 6'b110101, 1, "R9 busy");
        for (int k = 1; k < 5; k++) alloc1(0, 1, k, "R9 old mode");
        alloc1(0, 0, 0, "R9 old quota");
        for (int k = 0; k < 5; k++) free1(0, k, 0, "R9 drain");
        @(negedge clk);
        cfg_write = 1'b1; cfg_shared = 1'b1; cfg_port_en = 6'b000001;
        alloc_req = 1'b1; alloc_port = 3'd1;
        #1;
        chk("R9 cfg with alloc", int'(cfg_err), 1);
        @(negedge clk);
        cfg_write = 1'b0; alloc_req = 1'b0;
        free1(1, 5, 0, "R9 drain");
        alloc1(1, 1, 5, "R9 port1 still enabled fixed");
        free1(1, 5, 0, "R9 drain");
    endtask

    task automatic t_fixed_disabled();
        cfg1(1'b0, 6'b000011, 0, "R9 idle load");
        alloc1(3, 0, 0, "R3 disabled");
        for (int k = 0; k < 5; k++) alloc1(0, 1, k, "R3 own slice");
        alloc1(0, 0, 0, "R3 slice used up");
        chk("R3 free_count", int'(free_count), 25);
        for (int k = 0; k < 5; k++) free1(0, k, 0, "R3 drain");
    endtask

    task automatic t_shared();
        cfg1(1'b1, 6'b110101, 0, "R4 load");
        for (int k = 0; k < 8; k++) alloc1(0, 1, k, "R5 port0");
        alloc1(0, 0, 0, "R4 port0 quota 8");
        for (int k = 0; k < 8; k++) alloc1(2, 1, 8 + k, "R5 port2");
        alloc1(2, 0, 0, "R4 port2 quota 8");
        for (int k = 0; k < 7; k++) alloc1(4, 1, 16 + k, "R5 port4");
        alloc1(4, 0, 0, "R4 port4 quota 7");
        for (int k = 0; k < 7; k++) alloc1(5, 1, 23 + k, "R5 port5");
        alloc1(5, 0, 0, "R4 port5 quota 7");
        chk("R11 pool empty", int'(free_count), 0);
        alloc1(1, 0, 0, "R6 disabled port");
    endtask

    task automatic t_simul();
        free1(0, 0, 0, "R10 prep");
        chk("R10 prep count", int'(free_count), 1);
        @(negedge clk);
        alloc_req = 1'b1; alloc_port = 3'd0;
        free_req = 1'b1; free_port = 3'd0; free_seg = 5'd1;
        #1;
        chk("R10 grant", int'(alloc_grant), 1);
        chk("R10 seg not the freed one", int'(alloc_seg), 0);
        chk("R10 free ok", int'(free_err), 0);
        @(negedge clk);
        alloc_req = 1'b0; free_req = 1'b0;
        chk("R10 count kept", int'(free_count), 1);
        chk("R10 occ kept", occ_of(0), 7);
        alloc1(0, 1, 1, "R10 freed now visible");
        chk("R11 count", int'(free_count), 0);
        chk("R11 occ", occ_of(0), 8);
        cfg1(1'b0, 6'b111111, 1, "R9 full pool");
        alloc1(0, 0, 0, "R6 quota reached");
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fixed();
        t_cfg_busy();
        t_fixed_disabled();
        t_shared();
        t_simul();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule